// File: doc/BRIEF.md
# Non-Secure Permission Control Register

This block holds one 32-bit configuration word inside a system-control coprocessor. The word decides what software running in the non-secure state may use. It covers each of the general coprocessors 0 to 13, the cache lockdown entries and the TLB lockdown entries. It also governs the internal DMA engine and picks which page-table set, secure or non-secure, that engine walks. Coprocessor register-access requests arrive with their four encoding fields, a direction, a security flag and a privilege flag. The block checks the encoding and the access rights. It then updates the word, returns it, or raises an undefined-instruction pulse.

The stored bits also drive permission outputs to neighbouring units without any register stage. A per-coprocessor grant vector, a single indexed access check, and three lockdown/DMA enables let the pipeline, the MMU and the DMA engine consult the policy. They do so without a register read. The debug coprocessor (14) and the system-control coprocessor (15) are always granted.

Top module: `nsac_ctrl`

## Requirements
- R1: A request is selected only when opcode_1 = 0, CRn = 1, CRm = 1 and opcode_2 = 2. Any other encoding gives no undefined pulse, no read-valid and zero read data, and leaves the register unchanged.
- R2: A selected write with secure = 1 and privileged = 1 stores the write data, masked to the defined fields, at the next rising clock edge. A selected privileged read returns the stored value as read data in the cycle of the request, with read-valid high.
- R3: A selected privileged read with secure = 0 is allowed. A selected privileged write with secure = 0 raises undef_o in the request cycle and leaves the register unchanged.
- R4: Any selected request with privileged = 0 raises undef_o in the request cycle and changes nothing, in either security state.
- R5: Bits [31:19] and [15:14] are always stored and read as 0, whatever is written.
- R6: After reset every stored bit is 0.
- R7: cp_ns_grant_o[n] equals stored bit n for n = 0..13. Bits 14 and 15 of cp_ns_grant_o are always 1.
- R8: cp_access_ok_o is 1 when cp_check_secure_i = 1 or cp_ns_grant_o[cp_check_num_i] = 1.
- R9: ns_cache_lockdown_ok_o follows stored bit 16, ns_tlb_lockdown_ok_o follows bit 17, and dma_use_ns_tables_o follows bit 18 (1 = non-secure DMA use with non-secure page tables).
- R10: Whenever undef_o is 1, rdata_o is 0 and rd_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Register-access request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_opc1_i | input | 3 | opcode_1 field |
| req_crn_i | input | 4 | CRn field |
| req_crm_i | input | 4 | CRm field |
| req_opc2_i | input | 3 | opcode_2 field |
| req_secure_i | input | 1 | Requester is in the secure state |
| req_priv_i | input | 1 | Requester is privileged |
| req_wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero unless read-valid |
| rd_valid_o | output | 1 | Legal read of this register |
| undef_o | output | 1 | Undefined-instruction pulse |
| cp_check_num_i | input | 4 | Coprocessor number to check |
| cp_check_secure_i | input | 1 | Security state for the check |
| cp_access_ok_o | output | 1 | Indexed coprocessor access allowed |
| cp_ns_grant_o | output | 16 | Per-coprocessor non-secure grant |
| ns_cache_lockdown_ok_o | output | 1 | Non-secure cache lockdown allowed |
| ns_tlb_lockdown_ok_o | output | 1 | Non-secure TLB lockdown allowed |
| dma_use_ns_tables_o | output | 1 | DMA open to non-secure state, non-secure tables |

## Verification
Read data, read-valid and the undefined pulse are combinational, so they are due in the same cycle as the request. The permission outputs reflect a write only after the next rising edge, one cycle later. The bench drives each request on a falling edge and samples a quarter period later, before the rising edge. At that point the register still holds its value from before the write. The reference model is updated only after that sample, so the next request sees the new value through both reads and permission outputs.

// File: rtl/nsac_pkg.sv
package nsac_pkg;
  localparam int unsigned XLEN     = 32;
  localparam int unsigned NUM_CP   = 16;
  localparam int unsigned NS_CP    = 14;
  localparam int unsigned CP_IDX_W = $clog2(NUM_CP);
  localparam int unsigned CL_BIT   = 16;
  localparam int unsigned TL_BIT   = 17;
  localparam int unsigned DMA_BIT  = 18;

  localparam logic [2:0] SEL_OPC1 = 3'd0;
  localparam logic [3:0] SEL_CRN  = 4'd1;
  localparam logic [3:0] SEL_CRM  = 4'd1;
  localparam logic [2:0] SEL_OPC2 = 3'd2;

  function automatic logic [XLEN-1:0] calc_store_mask();
    logic [XLEN-1:0] m;
    m = '0;
    for (int i = 0; i < int'(NS_CP); i++) m[i] = 1'b1;
    m[CL_BIT]  = 1'b1;
    m[TL_BIT]  = 1'b1;
    m[DMA_BIT] = 1'b1;
    return m;
  endfunction

  localparam logic [XLEN-1:0] STORE_MASK = calc_store_mask();

  typedef struct packed {
    logic wr_en;
    logic rd_ok;
    logic undef;
  } acc_dec_t;
endpackage

// File: rtl/nsac_decode.sv
module nsac_decode
  import nsac_pkg::*;
(
  input  logic       valid_i,
  input  logic       write_i,
  input  logic [2:0] opc1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] opc2_i,
  input  logic       secure_i,
  input  logic       priv_i,
  output acc_dec_t   dec_o
);
  logic sel;

  assign sel = valid_i && (opc1_i == SEL_OPC1) && (crn_i == SEL_CRN)
               && (crm_i == SEL_CRM) && (opc2_i == SEL_OPC2);

  always_comb begin
    dec_o.wr_en = sel && write_i && priv_i && secure_i;
    dec_o.rd_ok = sel && !write_i && priv_i;
    // user mode always traps; non-secure privileged traps on write only
    dec_o.undef = sel && (!priv_i || (write_i && !secure_i));
  end
endmodule

// File: rtl/nsac_store.sv
module nsac_store
  import nsac_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] q_o
);
  for (genvar i = 0; i < int'(XLEN); i++) begin : g_bit
    if (STORE_MASK[i]) begin : g_flop
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      bit_q <= 1'b0;
        else if (wr_en_i) bit_q <= wdata_i[i];
      end
      assign q_o[i] = bit_q;
    end else begin : g_rsvd
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/nsac_perm.sv
module nsac_perm
  import nsac_pkg::*;
(
  input  logic [NS_CP-1:0]    cp_en_i,
  input  logic                cl_i,
  input  logic                tl_i,
  input  logic                dma_i,
  input  logic [CP_IDX_W-1:0] chk_num_i,
  input  logic                chk_secure_i,
  output logic [NUM_CP-1:0]   grant_o,
  output logic                access_ok_o,
  output logic                cl_ok_o,
  output logic                tl_ok_o,
  output logic                dma_ns_o
);
  for (genvar n = 0; n < int'(NUM_CP); n++) begin : g_cp
    if (n < int'(NS_CP)) begin : g_ctl
      assign grant_o[n] = cp_en_i[n];
    end else begin : g_fixed
      assign grant_o[n] = 1'b1; // debug and system control never blocked
    end
  end

  assign access_ok_o = chk_secure_i | grant_o[chk_num_i];
  assign cl_ok_o     = cl_i;
  assign tl_ok_o     = tl_i;
  assign dma_ns_o    = dma_i;
endmodule

// File: rtl/nsac_ctrl.sv
module nsac_ctrl
  import nsac_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [2:0]          req_opc1_i,
  input  logic [3:0]          req_crn_i,
  input  logic [3:0]          req_crm_i,
  input  logic [2:0]          req_opc2_i,
  input  logic                req_secure_i,
  input  logic                req_priv_i,
  input  logic [XLEN-1:0]     req_wdata_i,
  output logic [XLEN-1:0]     rdata_o,
  output logic                rd_valid_o,
  output logic                undef_o,
  input  logic [CP_IDX_W-1:0] cp_check_num_i,
  input  logic                cp_check_secure_i,
  output logic                cp_access_ok_o,
  output logic [NUM_CP-1:0]   cp_ns_grant_o,
  output logic                ns_cache_lockdown_ok_o,
  output logic                ns_tlb_lockdown_ok_o,
  output logic                dma_use_ns_tables_o
);
  acc_dec_t        dec;
  logic [XLEN-1:0] reg_q;

  nsac_decode u_dec (
    .valid_i  (req_valid_i),
    .write_i  (req_write_i),
    .opc1_i   (req_opc1_i),
    .crn_i    (req_crn_i),
    .crm_i    (req_crm_i),
    .opc2_i   (req_opc2_i),
    .secure_i (req_secure_i),
    .priv_i   (req_priv_i),
    .dec_o    (dec)
  );

  nsac_store u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (dec.wr_en),
    .wdata_i (req_wdata_i),
    .q_o     (reg_q)
  );

  nsac_perm u_perm (
    .cp_en_i      (reg_q[NS_CP-1:0]),
    .cl_i         (reg_q[CL_BIT]),
    .tl_i         (reg_q[TL_BIT]),
    .dma_i        (reg_q[DMA_BIT]),
    .chk_num_i    (cp_check_num_i),
    .chk_secure_i (cp_check_secure_i),
    .grant_o      (cp_ns_grant_o),
    .access_ok_o  (cp_access_ok_o),
    .cl_ok_o      (ns_cache_lockdown_ok_o),
    .tl_ok_o      (ns_tlb_lockdown_ok_o),
    .dma_ns_o     (dma_use_ns_tables_o)
  );

  assign rdata_o    = dec.rd_ok ? reg_q : '0;
  assign rd_valid_o = dec.rd_ok;
  assign undef_o    = dec.undef;
endmodule

// File: rtl/nsac_ctrl_chk.sv
module nsac_ctrl_chk
  import nsac_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                req_write_i,
  input logic [2:0]          req_opc1_i,
  input logic [3:0]          req_crn_i,
  input logic [3:0]          req_crm_i,
  input logic [2:0]          req_opc2_i,
  input logic                req_secure_i,
  input logic                req_priv_i,
  input logic [XLEN-1:0]     req_wdata_i,
  input logic [XLEN-1:0]     rdata_o,
  input logic                rd_valid_o,
  input logic                undef_o,
  input logic [NUM_CP-1:0]   cp_ns_grant_o,
  input logic                dma_use_ns_tables_o,
  input logic [XLEN-1:0]     reg_q
);
  logic sel_hit;
  assign sel_hit = req_valid_i && req_opc1_i == 3'd0 && req_crn_i == 4'd1
                   && req_crm_i == 4'd1 && req_opc2_i == 3'd2;

  // R1
  miss_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_hit |-> (!undef_o && !rd_valid_o && rdata_o == '0));

  // R2
  sec_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_hit && req_write_i && req_secure_i && req_priv_i)
      |=> reg_q == ($past(req_wdata_i) & STORE_MASK));

  // R3
  ns_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_hit && req_write_i && !(req_secure_i && req_priv_i)) |=> $stable(reg_q));

  // R4
  user_undef_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_hit && !req_priv_i) |-> undef_o);

  // R5
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~STORE_MASK) == '0);

  // R7
  fixed_cp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_ns_grant_o[NUM_CP-1:NS_CP] == '1);

  // R9
  dma_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_use_ns_tables_o == reg_q[DMA_BIT]);

  // R10
  undef_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> (rdata_o == '0 && !rd_valid_o));
endmodule

bind nsac_ctrl nsac_ctrl_chk u_chk (
  .clk_i               (clk_i),
  .rst_ni              (rst_ni),
  .req_valid_i         (req_valid_i),
  .req_write_i         (req_write_i),
  .req_opc1_i          (req_opc1_i),
  .req_crn_i           (req_crn_i),
  .req_crm_i           (req_crm_i),
  .req_opc2_i          (req_opc2_i),
  .req_secure_i        (req_secure_i),
  .req_priv_i          (req_priv_i),
  .req_wdata_i         (req_wdata_i),
  .rdata_o             (rdata_o),
  .rd_valid_o          (rd_valid_o),
  .undef_o             (undef_o),
  .cp_ns_grant_o       (cp_ns_grant_o),
  .dma_use_ns_tables_o (dma_use_ns_tables_o),
  .reg_q               (reg_q)
);

// File: tb/sim_nsac_ctrl.sv
module sim_nsac_ctrl;
  localparam int CLK_P = 10;
  localparam logic [31:0] MASK = 32'h0007_3FFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, wr = 1'b0, sec = 1'b0, priv = 1'b0;
  logic [2:0]  opc1 = '0, opc2 = '0;
  logic [3:0]  crn = '0, crm = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  cnum = '0;
  logic        csec = 1'b0;
  logic [31:0] rdata;
  logic        rdv, undef, ok, cl, tl, dma;
  logic [15:0] grant;

  int checks = 0, errors = 0;
  logic [31:0] mdl = '0;

  typedef struct {
    string       tag;
    logic [31:0] rdata;
    logic        rdv, undef, ok, cl, tl, dma;
    logic [15:0] grant;
  } exp_t;
  exp_t sbq[$];
  event mon_ev;

  always #(CLK_P/2) clk = ~clk;

  nsac_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(wr),
    .req_opc1_i(opc1), .req_crn_i(crn), .req_crm_i(crm), .req_opc2_i(opc2),
    .req_secure_i(sec), .req_priv_i(priv), .req_wdata_i(wdata),
    .rdata_o(rdata), .rd_valid_o(rdv), .undef_o(undef),
    .cp_check_num_i(cnum), .cp_check_secure_i(csec), .cp_access_ok_o(ok),
    .cp_ns_grant_o(grant), .ns_cache_lockdown_ok_o(cl),
    .ns_tlb_lockdown_ok_o(tl), .dma_use_ns_tables_o(dma)
  );

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per request and compares outputs
  initial forever begin
    @(mon_ev);
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      cmp(e.tag, "rdata", rdata, e.rdata);
      cmp(e.tag, "rd_valid", {31'b0, rdv}, {31'b0, e.rdv});
      cmp(e.tag, "undef", {31'b0, undef}, {31'b0, e.undef});
      cmp(e.tag, "cp_ok", {31'b0, ok}, {31'b0, e.ok});
      cmp(e.tag, "grant", {16'b0, grant}, {16'b0, e.grant});
      cmp(e.tag, "lockdn", {29'b0, cl, tl, dma}, {29'b0, e.cl, e.tl, e.dma});
    end
  end

  // driver: issues one request, predicts results from the model
  task automatic req(string tag, logic v, logic w, logic s, logic p,
                     logic [31:0] d, logic [3:0] cn, logic cs,
                     logic [2:0] o1 = 3'd0, logic [3:0] n = 4'd1,
                     logic [3:0] m = 4'd1, logic [2:0] o2 = 3'd2);
    exp_t e;
    logic hit, legal_rd, legal_wr;
    @(negedge clk);
    valid = v; wr = w; sec = s; priv = p; wdata = d; cnum = cn; csec = cs;
    opc1 = o1; crn = n; crm = m; opc2 = o2;
    hit      = v && o1 == 3'd0 && n == 4'd1 && m == 4'd1 && o2 == 3'd2;
    legal_rd = hit && !w && p;
    legal_wr = hit && w && p && s;
    e.tag   = tag;
    e.undef = hit && (!p || (w && !s));
    e.rdv   = legal_rd;
    e.rdata = legal_rd ? mdl : 32'h0;
    e.grant = {2'b11, mdl[13:0]};
    e.ok    = cs || cn >= 4'd14 || mdl[cn];
    e.cl    = mdl[16];
    e.tl    = mdl[17];
    e.dma   = mdl[18];
    sbq.push_back(e);
    #(CLK_P/4);
    -> mon_ev;
    #1;
    if (legal_wr) mdl = d & MASK;
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P*3 + 2);
    rst_n = 1'b1;
    // R6 reset state
    req("R6_reset_rd", 1, 0, 1, 1, 0, 4'd3, 0);
    req("R6_reset_cp14", 0, 0, 0, 0, 0, 4'd14, 0);
    // R2 secure write, read back; R5 reserved bits dropped
    req("R2_wr_all", 1, 1, 1, 1, 32'hFFFF_FFFF, 4'd5, 0);
    req("R5_rd_all", 1, 0, 1, 1, 0, 4'd5, 0);
    // R3 non-secure privileged read ok, write traps
    req("R3_ns_rd", 1, 0, 0, 1, 0, 4'd13, 0);
    req("R3_ns_wr", 1, 1, 0, 1, 32'h0, 4'd0, 0);
    req("R3_ns_hold", 1, 0, 1, 1, 0, 4'd0, 0);
    // R4 user mode traps in both worlds
    req("R4_usr_s_rd", 1, 0, 1, 0, 0, 4'd1, 0);
    req("R4_usr_s_wr", 1, 1, 1, 0, 32'h0, 4'd1, 0);
    req("R4_usr_ns_rd", 1, 0, 0, 0, 0, 4'd1, 1);
    req("R4_usr_ns_wr", 1, 1, 0, 0, 32'h0, 4'd1, 1);
    req("R4_hold", 1, 0, 1, 1, 0, 4'd2, 0);
    // R1 other encodings ignored
    req("R1_opc2", 1, 1, 1, 1, 32'h0, 4'd0, 0, 3'd0, 4'd1, 4'd1, 3'd0);
    req("R1_crm",  1, 1, 1, 1, 32'h0, 4'd0, 0, 3'd0, 4'd1, 4'd0, 3'd2);
    req("R1_crn",  1, 1, 0, 0, 32'h0, 4'd0, 0, 3'd0, 4'd2, 4'd1, 3'd2);
    req("R1_opc1", 1, 0, 0, 0, 32'h0, 4'd0, 0, 3'd1, 4'd1, 4'd1, 3'd2);
    req("R1_novalid", 0, 1, 1, 1, 32'h0, 4'd0, 0);
    req("R1_hold", 1, 0, 1, 1, 0, 4'd0, 0);
    // R7 R8 R9 mixed pattern
    req("R9_wr_mix", 1, 1, 1, 1, 32'h0005_2A55, 4'd1, 0);
    req("R8_cp1_ns", 1, 0, 1, 1, 0, 4'd1, 0);
    req("R8_cp1_s", 0, 0, 0, 0, 0, 4'd1, 1);
    req("R7_cp0_ns", 0, 0, 0, 0, 0, 4'd0, 0);
    req("R7_cp15_ns", 0, 0, 0, 0, 0, 4'd15, 0);
    req("R9_wr_tl", 1, 1, 1, 1, 32'h0002_0000, 4'd13, 0);
    req("R9_rd_tl", 1, 0, 0, 1, 0, 4'd13, 0);
    // R5 reserved-only write stores zero
    req("R5_wr_rsvd", 1, 1, 1, 1, 32'hFFF8_C000, 4'd6, 0);
    req("R5_rd_rsvd", 1, 0, 1, 1, 0, 4'd6, 0);
    // R10 trap read data zero after non-zero contents
    req("R10_wr", 1, 1, 1, 1, 32'h0001_3FFF, 4'd7, 0);
    req("R10_usr_rd", 1, 0, 1, 0, 0, 4'd7, 0);
    req("R10_fin", 1, 0, 0, 1, 0, 4'd7, 0);
    @(negedge clk);
    valid = 1'b0;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule